// File: doc/BRIEF.md
# Grouped DMA Operation Queue

This block sits in front of a block-copy DMA engine and holds operation descriptors until software decides to start them. Each write on the command port carries one descriptor, a group number (0 or 1), a destination memory type and a launch flag. An accepted write takes one of the shared slots and starts no transfer. Software reads the free-slot count and writes again only while that count is above zero.

The write that carries the launch flag closes its group. From then on, the slots of that group are handed to the engine one at a time, oldest first. The engine pulses a done strobe for each operation it completes, and each strobe frees the oldest slot. When the last operation of a launched group completes, that group's interrupt flag is set. Software clears the flag by writing a one to it.

Each group has two stall counters, one for read stalls and one for write stalls. They count while the engine works on that group's operations and a global enable is high. A group's counters restart from zero when that group launches.

Top module: `dma_group_queue`

## Requirements
- R1: After reset, free_slots equals NUM_SLOTS (20). eng_valid, irq, grp_busy, err_launch and err_dst are all zero.
- R2: A write accepted to a group that has not launched takes one slot, so free_slots drops by one on the next cycle. eng_valid stays low until that group launches.
- R3: After a launch, the engine is offered operations in the order they were written. eng_desc and eng_grp show the oldest stored operation. They stay stable until eng_done.
- R4: An eng_done strobe while eng_valid is high frees the oldest slot, so free_slots rises by one on the next cycle.
- R5: When the last operation of a launched group completes, irq[g] is set and grp_busy[g] is cleared. irq[g] stays set until software writes a one to irq_clr[g].
- R6: A write while free_slots is zero is refused. free_slots stays at zero.
- R7: A write to a group that is still busy is refused. If that write carries the launch flag, it also sets err_launch, and err_launch then stays set.
- R8: A write whose destination type differs from the type of operations already cached in the same group is refused and sets err_dst, which stays set.
- R9: While perf_en is high and eng_valid is high, the counters of the group shown on eng_grp count cycles with rd_stall_in high and cycles with wr_stall_in high. Bits [CNT_W-1:0] hold group 0 and the upper half holds group 1. Both counters of a group reset to zero when that group launches.
- R10: An eng_done strobe while eng_valid is low has no effect on free_slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_we | input | 1 | Write one operation descriptor |
| op_desc | input | DESC_W | Descriptor contents |
| op_grp | input | 1 | Target group |
| op_dst | input | 1 | Destination memory type |
| op_launch | input | 1 | This write closes and launches the group |
| irq_clr | input | 2 | Write-one-to-clear for each group interrupt |
| perf_en | input | 1 | Global enable for the stall counters |
| rd_stall_in | input | 1 | Engine reports a read stall this cycle |
| wr_stall_in | input | 1 | Engine reports a write stall this cycle |
| eng_done | input | 1 | Engine has completed the offered operation |
| free_slots | output | SLOT_W | Number of unused slots |
| eng_valid | output | 1 | An operation is offered to the engine |
| eng_desc | output | DESC_W | Descriptor of the offered operation |
| eng_grp | output | 1 | Group of the offered operation |
| eng_dst | output | 1 | Destination type of the offered operation |
| irq | output | 2 | Group completion interrupt flags |
| grp_busy | output | 2 | Group launched and not yet finished |
| err_launch | output | 1 | Sticky flag: launch written to a busy group |
| err_dst | output | 1 | Sticky flag: destination type mismatch |
| rd_stall_cnt | output | 2*CNT_W | Read stall counters, group 1 in the upper half |
| wr_stall_cnt | output | 2*CNT_W | Write stall counters, group 1 in the upper half |

## Verification
Corrupt slot pointers show up on eng_desc as an operation delivered out of order or repeated. This is visible on the first dispatch after the fault. A wrong occupancy count shows up in free_slots on the cycle after the bad push or pop. A wrong per-group pending count is slower to see. It shows as irq firing one operation early, or never firing, when that group drains. That is why the bench drains a full 20-slot group and checks every descriptor, the slot count and the interrupt.

// File: rtl/dma_group_queue.sv
module dma_group_queue #(
  parameter int NUM_SLOTS = 20,
  parameter int DESC_W    = 32,
  parameter int CNT_W     = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
  localparam int PTR_W    = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_we,
  input  logic [DESC_W-1:0]   op_desc,
  input  logic                op_grp,
  input  logic                op_dst,
  input  logic                op_launch,
  input  logic [1:0]          irq_clr,
  input  logic                perf_en,
  input  logic                rd_stall_in,
  input  logic                wr_stall_in,
  input  logic                eng_done,
  output logic [SLOT_W-1:0]   free_slots,
  output logic                eng_valid,
  output logic [DESC_W-1:0]   eng_desc,
  output logic                eng_grp,
  output logic                eng_dst,
  output logic [1:0]          irq,
  output logic [1:0]          grp_busy,
  output logic                err_launch,
  output logic                err_dst,
  output logic [2*CNT_W-1:0]  rd_stall_cnt,
  output logic [2*CNT_W-1:0]  wr_stall_cnt
);

  logic [DESC_W-1:0]           desc_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]        grp_q, dst_q;
  logic [PTR_W-1:0]            wp, rp;
  logic [SLOT_W-1:0]           used;
  logic [1:0][SLOT_W-1:0]      pend;
  logic [1:0]                  active, gdst;
  logic [1:0][CNT_W-1:0]       rdc, wrc;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  wire head_grp = grp_q[rp];
  wire tgt_busy = active[op_grp];
  wire dst_bad  = (pend[op_grp] != '0) && (op_dst != gdst[op_grp]);
  wire full     = (used == SLOT_W'(NUM_SLOTS));
  wire push     = op_we && !tgt_busy && !full && !dst_bad;
  wire pop      = eng_valid && eng_done;

  assign eng_valid    = (used != '0) && active[head_grp];
  assign eng_desc     = desc_q[rp];
  assign eng_grp      = head_grp;
  assign eng_dst      = dst_q[rp];
  assign free_slots   = SLOT_W'(NUM_SLOTS) - used;
  assign grp_busy     = active;
  assign rd_stall_cnt = rdc;
  assign wr_stall_cnt = wrc;

  always_ff @(posedge clk) begin
    if (push) begin
      desc_q[wp] <= op_desc;
      grp_q[wp]  <= op_grp;
      dst_q[wp]  <= op_dst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp         <= '0;
      rp         <= '0;
      used       <= '0;
      pend       <= '0;
      active     <= '0;
      gdst       <= '0;
      irq        <= '0;
      rdc        <= '0;
      wrc        <= '0;
      err_launch <= 1'b0;
      err_dst    <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      used       <= used + SLOT_W'(push) - SLOT_W'(pop);
      err_launch <= err_launch | (op_we && op_launch && tgt_busy);
      err_dst    <= err_dst | (op_we && !tgt_busy && dst_bad);
      for (int g = 0; g < 2; g++) begin
        automatic logic gpush = push && (op_grp == 1'(g));
        automatic logic gpop  = pop && (head_grp == 1'(g));
        pend[g] <= pend[g] + SLOT_W'(gpush) - SLOT_W'(gpop);
        if (gpush) gdst[g] <= op_dst;
        if (gpop && pend[g] == SLOT_W'(1)) begin
          active[g] <= 1'b0;
          irq[g]    <= 1'b1;
        end else if (irq_clr[g]) begin
          irq[g]    <= 1'b0;
        end
        if (gpush && op_launch) begin
          active[g] <= 1'b1;
          rdc[g]    <= '0;
          wrc[g]    <= '0;
        end else if (perf_en && eng_valid && head_grp == 1'(g)) begin
          rdc[g] <= rdc[g] + CNT_W'(rd_stall_in);
          wrc[g] <= wrc[g] + CNT_W'(wr_stall_in);
        end
      end
    end
  end

endmodule

// File: rtl/dma_group_queue_chk.sv
module dma_group_queue_chk #(
  parameter int NUM_SLOTS = 20,
  parameter int DESC_W    = 32,
  parameter int SLOT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_we,
  input logic [1:0]        irq_clr,
  input logic              eng_done,
  input logic [SLOT_W-1:0] free_slots,
  input logic              eng_valid,
  input logic [DESC_W-1:0] eng_desc,
  input logic              eng_grp,
  input logic [1:0]        irq,
  input logic [1:0]        grp_busy,
  input logic              err_launch,
  input logic              err_dst
);

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= SLOT_W'(NUM_SLOTS)); // R6

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots == '0) && !(eng_valid && eng_done) |=> free_slots == '0); // R6

  AST_DISPATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> grp_busy[eng_grp]); // R3

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_done |=> eng_valid && $stable(eng_desc)); // R3

  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_done && !op_we |=> free_slots == $past(free_slots) + 1'b1); // R4

  AST_IRQ_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] && !irq_clr[0] |=> irq[0]); // R5

  AST_IRQ_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] && !irq_clr[1] |=> irq[1]); // R5

  AST_ERR_LAUNCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_launch |=> err_launch); // R7

  AST_ERR_DST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_dst |=> err_dst); // R8

  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_valid && eng_done && !op_we |=> free_slots == $past(free_slots)); // R10

endmodule

bind dma_group_queue dma_group_queue_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DESC_W(DESC_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_we(op_we), .irq_clr(irq_clr),
  .eng_done(eng_done), .free_slots(free_slots), .eng_valid(eng_valid),
  .eng_desc(eng_desc), .eng_grp(eng_grp), .irq(irq), .grp_busy(grp_busy),
  .err_launch(err_launch), .err_dst(err_dst)
);

// File: tb/test_dma_group_queue.sv
module test_dma_group_queue;
  localparam int NS = 20, DW = 32, CW = 16, SW = 5;

  logic clk = 0, rst_n = 0;
  logic op_we = 0, op_grp = 0, op_dst = 0, op_launch = 0;
  logic [DW-1:0] op_desc = '0;
  logic [1:0] irq_clr = '0;
  logic perf_en = 0, rd_stall_in = 0, wr_stall_in = 0, eng_done = 0;
  logic [SW-1:0] free_slots;
  logic eng_valid, eng_grp, eng_dst, err_launch, err_dst;
  logic [DW-1:0] eng_desc;
  logic [1:0] irq, grp_busy;
  logic [2*CW-1:0] rd_stall_cnt, wr_stall_cnt;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_group_queue #(.NUM_SLOTS(NS), .DESC_W(DW), .CNT_W(CW)) i_dma_group_queue (
    .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_desc(op_desc), .op_grp(op_grp),
    .op_dst(op_dst), .op_launch(op_launch), .irq_clr(irq_clr), .perf_en(perf_en),
    .rd_stall_in(rd_stall_in), .wr_stall_in(wr_stall_in), .eng_done(eng_done),
    .free_slots(free_slots), .eng_valid(eng_valid), .eng_desc(eng_desc),
    .eng_grp(eng_grp), .eng_dst(eng_dst), .irq(irq), .grp_busy(grp_busy),
    .err_launch(err_launch), .err_dst(err_dst),
    .rd_stall_cnt(rd_stall_cnt), .wr_stall_cnt(wr_stall_cnt));

  // {launch, desc[15:0], expected free_slots, expected eng_valid}
  localparam logic [22:0] VEC [4] = '{
    {1'b0, 16'hA001, 5'd19, 1'b0},
    {1'b0, 16'hA002, 5'd18, 1'b0},
    {1'b0, 16'hA003, 5'd17, 1'b0},
    {1'b1, 16'hA004, 5'd16, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic g, input logic t, input logic l);
    op_we = 1; op_desc = d; op_grp = g; op_dst = t; op_launch = l;
    tick();
    op_we = 0; op_launch = 0;
  endtask

  task automatic done_one;
    eng_done = 1;
    tick();
    eng_done = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 free", free_slots, NS);
    chk("R1 valid", eng_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 busy", grp_busy, 0);
    chk("R1 errs", {err_launch, err_dst}, 0);

    for (int i = 0; i < 4; i++) begin
      wr(DW'(VEC[i][21:6]), 1'b0, 1'b0, VEC[i][22]);
      chk("R2 free after write", free_slots, VEC[i][5:1]);
      chk("R2 eng_valid before/after launch", eng_valid, VEC[i][0]);
    end

    perf_en = 1; rd_stall_in = 1;
    repeat (3) tick();
    rd_stall_in = 0;
    chk("R9 rd stall grp0", rd_stall_cnt[CW-1:0], 3);
    chk("R3 head stable during stall", eng_desc, DW'(VEC[0][21:6]));

    for (int i = 0; i < 4; i++) begin
      chk("R3 dispatch order", eng_desc, DW'(VEC[i][21:6]));
      chk("R3 dispatch grp", eng_grp, 0);
      done_one();
      chk("R4 free after done", free_slots, 17 + i);
    end
    chk("R5 irq0 set", irq, 2'b01);
    chk("R5 busy0 cleared", grp_busy, 0);
    chk("R5 valid low after drain", eng_valid, 0);
    tick();
    chk("R5 irq0 holds", irq, 2'b01);
    irq_clr = 2'b01; tick(); irq_clr = 0;
    chk("R5 irq0 cleared", irq, 0);

    done_one();
    chk("R10 idle done ignored", free_slots, NS);

    wr(32'hB001, 1'b1, 1'b1, 1'b0);
    chk("R2 grp1 first write", free_slots, 19);
    wr(32'hB002, 1'b1, 1'b0, 1'b0);
    chk("R8 mismatch refused", free_slots, 19);
    chk("R8 err_dst set", err_dst, 1);
    wr(32'hB003, 1'b1, 1'b1, 1'b1);
    chk("R3 grp1 launch", {eng_valid, eng_grp}, 2'b11);
    chk("R3 grp1 head", eng_desc, 32'hB001);
    wr_stall_in = 1;
    repeat (2) tick();
    wr_stall_in = 0;
    chk("R9 wr stall grp1", wr_stall_cnt[2*CW-1:CW], 2);
    chk("R9 grp0 rd untouched", rd_stall_cnt[CW-1:0], 3);
    wr(32'hC001, 1'b1, 1'b1, 1'b1);
    chk("R7 launch to busy refused", free_slots, 18);
    chk("R7 err_launch set", err_launch, 1);
    wr(32'hC002, 1'b1, 1'b1, 1'b0);
    chk("R7 plain write to busy refused", free_slots, 18);
    chk("R8 err_dst sticky", err_dst, 1);
    done_one();
    chk("R3 grp1 second", eng_desc, 32'hB003);
    done_one();
    chk("R5 irq1 set", irq, 2'b10);
    irq_clr = 2'b10; tick(); irq_clr = 0;
    chk("R5 irq1 cleared", irq, 0);

    for (int i = 0; i < NS; i++) wr(32'hD000 + DW'(i), 1'b0, 1'b0, i == NS - 1);
    chk("R6 queue full", free_slots, 0);
    chk("R9 grp0 cleared on launch", rd_stall_cnt[CW-1:0], 0);
    wr(32'hE001, 1'b1, 1'b0, 1'b0);
    chk("R6 write refused when full", free_slots, 0);
    chk("R7 err_launch stays", err_launch, 1);
    for (int i = 0; i < NS; i++) begin
      chk("R3 full drain order", eng_desc, 32'hD000 + DW'(i));
      done_one();
    end
    chk("R4 all slots free", free_slots, NS);
    chk("R5 irq0 after full group", irq, 2'b01);

    finish_run();
  end
endmodule